// File: doc/BRIEF.md
# Scan Chain with Frozen Logic Outputs and Toggle Metering

This block is a parameterised chain of multiplexed-input scan flip-flops. With the shift control high, the cells form a shift register from a serial input to a serial output. With it low, every cell loads its functional input in parallel. A test is applied in three steps. First the stimulus is shifted in over `CHAIN_LEN` clocks. Then one clock is given with shift low, which captures the logic response. Finally the response is shifted out while the next stimulus is shifted in.

A gating control can keep the values presented to the downstream combinational logic steady while the chain shifts. Shifting activity then never reaches that logic. Every cycle in which shift is low records the chain's next contents in a hold register. While gating and shift are both high, the logic outputs show that held copy instead of the live cells.

The block also meters switching activity. On each clock it counts how many cells change value, as the popcount of the old contents XOR the new contents. Shift clocks and capture clocks add into two separate saturating counters, which a synchronous clear input resets. The counts give a shift-power figure and a capture-power figure for a vector set or a chain ordering.

Top module: `gated_scan_chain`

## Requirements
- R1: While reset is asserted, and until the core leaves reset, every cell, the hold register and both counters are zero, so `scan_out`, `logic_q`, `shift_toggles` and `capture_toggles` read 0.
- R2: On a clock with `scan_en` high, cell 0 loads `scan_in` and cell i loads cell i-1. `scan_out` is cell `CHAIN_LEN-1`.
- R3: On a clock with `scan_en` low, cell i loads `func_d[i]`.
- R4: While `gate_en` and `scan_en` are both high, `logic_q` equals the chain contents left by the most recent clock that had `scan_en` low. Shifting does not change it.
- R5: While `gate_en` is low, `logic_q` equals the live chain contents, including during shifting.
- R6: While `scan_en` is low, `logic_q` equals the live chain contents whatever the value of `gate_en`.
- R7: Each clock with `scan_en` high adds the number of cells that change on that clock to `shift_toggles`. `capture_toggles` is left unchanged.
- R8: Each clock with `scan_en` low adds the number of cells that change on that clock to `capture_toggles`. `shift_toggles` is left unchanged.
- R9: Each counter stops at 2^`CNT_W`-1 and never wraps.
- R10: A clock with `cnt_clr` high sets both counters to 0, overriding any addition on that clock. The chain still shifts or captures as usual on that clock.
- R11: Reset is applied at once on `rst_n` low. The core leaves reset on the second rising clock edge after `rst_n` rises, and the chain acts from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift, 0 = capture/normal load |
| gate_en | input | 1 | 1 = hold logic outputs steady while shifting |
| scan_in | input | 1 | Serial input to cell 0 |
| func_d | input | CHAIN_LEN | Functional input to each cell |
| cnt_clr | input | 1 | Synchronous clear of both toggle counters |
| scan_out | output | 1 | Serial output, last cell |
| logic_q | output | CHAIN_LEN | Values driven into the combinational logic |
| shift_toggles | output | CNT_W | Saturating count of toggles on shift clocks |
| capture_toggles | output | CNT_W | Saturating count of toggles on capture clocks |

## Verification
The bench builds the block with `CHAIN_LEN` = 8 and `CNT_W` = 6. With eight cells, a complete shift-in, capture and shift-out pass takes only a few dozen clocks. The 6-bit counters reach their ceiling of 63 after about eight shifts of an alternating pattern, so saturation is reached in a short run. Each shift clock can toggle at most eight cells. That limit, together with a ceiling of 63 that is not a multiple of eight, makes the final addition before saturation overshoot the ceiling, so clamping is exercised as well as reaching the limit.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scan_cell_array.sv
module scan_cell_array #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scan_pkg::scan_mode_e mode,
  input  logic                 gate_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] chain_q,
  output logic [CHAIN_LEN-1:0] chain_d,
  output logic [CHAIN_LEN-1:0] logic_q
);
  import scan_pkg::*;

  logic [CHAIN_LEN-1:0] serial_src;
  logic [CHAIN_LEN-1:0] hold_q;
  logic [CHAIN_LEN-1:0] hold_d;
  logic                 hold_en;
  logic                 freeze;

  assign serial_src = {chain_q[CHAIN_LEN-2:0], scan_in};

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    always_comb begin
      if (mode == MODE_SHIFT) chain_d[i] = serial_src[i];
      else                    chain_d[i] = func_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_d[i];
    end
  end

  assign hold_en = (mode == MODE_LOAD);

  always_comb begin
    hold_d = hold_q;
    if (hold_en) hold_d = chain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign freeze  = gate_en && (mode == MODE_SHIFT);
  assign logic_q = freeze ? hold_q : chain_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] CEIL = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    sum   = SUM_W'(cnt) + SUM_W'(inc);
    cnt_d = cnt;
    if (clr)              cnt_d = '0;
    else if (inc_en) begin
      if (sum > CEIL)     cnt_d = {CNT_W{1'b1}};
      else                cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/toggle_meter.sv
module toggle_meter #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  scan_pkg::scan_mode_e mode,
  input  logic [CHAIN_LEN-1:0] cur_state,
  input  logic [CHAIN_LEN-1:0] nxt_state,
  output logic [CNT_W-1:0]     shift_cnt,
  output logic [CNT_W-1:0]     capture_cnt
);
  import scan_pkg::*;
  localparam int TOG_W = $clog2(CHAIN_LEN + 1);

  logic [CHAIN_LEN-1:0] diff;
  logic [TOG_W-1:0]     toggles;
  logic [1:0]           sel;
  logic [CNT_W-1:0]     cnt_arr [2];

  assign diff = cur_state ^ nxt_state;

  always_comb begin
    toggles = '0;
    for (int i = 0; i < CHAIN_LEN; i++) toggles = toggles + TOG_W'(diff[i]);
  end

  assign sel[0] = (mode == MODE_LOAD);
  assign sel[1] = (mode == MODE_SHIFT);

  for (genvar k = 0; k < 2; k++) begin : g_acc
    sat_counter #(.CNT_W(CNT_W), .INC_W(TOG_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .inc_en (sel[k]),
      .inc    (toggles),
      .cnt    (cnt_arr[k])
    );
  end

  assign capture_cnt = cnt_arr[0];
  assign shift_cnt   = cnt_arr[1];
endmodule

// File: rtl/gated_scan_chain.sv
module gated_scan_chain #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 gate_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_d,
  input  logic                 cnt_clr,
  output logic                 scan_out,
  output logic [CHAIN_LEN-1:0] logic_q,
  output logic [CNT_W-1:0]     shift_toggles,
  output logic [CNT_W-1:0]     capture_toggles
);
  import scan_pkg::*;

  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  scan_mode_e           mode;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] chain_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign mode = scan_en ? MODE_SHIFT : MODE_LOAD;

  scan_cell_array #(.CHAIN_LEN(CHAIN_LEN)) u_cells (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mode    (mode),
    .gate_en (gate_en),
    .scan_in (scan_in),
    .func_d  (func_d),
    .chain_q (chain_q),
    .chain_d (chain_d),
    .logic_q (logic_q)
  );

  toggle_meter #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_meter (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .clr         (cnt_clr),
    .mode        (mode),
    .cur_state   (chain_q),
    .nxt_state   (chain_d),
    .shift_cnt   (shift_toggles),
    .capture_cnt (capture_toggles)
  );

  assign scan_out = chain_q[CHAIN_LEN-1];
endmodule

// File: rtl/scan_chain_chk.sv
module scan_chain_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic                 scan_en,
  input logic                 gate_en,
  input logic                 scan_in,
  input logic [CHAIN_LEN-1:0] func_d,
  input logic                 cnt_clr,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic [CHAIN_LEN-1:0] logic_q,
  input logic [CNT_W-1:0]     shift_toggles,
  input logic [CNT_W-1:0]     capture_toggles
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    scan_en |=> chain_q == {$past(chain_q[CHAIN_LEN-2:0]), $past(scan_in)});

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !scan_en |=> chain_q == $past(func_d));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (scan_en && gate_en) ##1 (scan_en && gate_en) |-> $stable(logic_q));

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !gate_en |-> logic_q == chain_q);

  p_normal_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !scan_en |-> logic_q == chain_q);

  p_cap_idle_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (scan_en && !cnt_clr) |=> $stable(capture_toggles));

  p_shift_idle_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!scan_en && !cnt_clr) |=> $stable(shift_toggles));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cnt_clr |=> (shift_toggles >= $past(shift_toggles)) &&
                 (capture_toggles >= $past(capture_toggles)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    cnt_clr |=> (shift_toggles == '0) && (capture_toggles == '0));
endmodule

bind gated_scan_chain scan_chain_chk #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_core_n      (rst_core_n),
  .scan_en         (scan_en),
  .gate_en         (gate_en),
  .scan_in         (scan_in),
  .func_d          (func_d),
  .cnt_clr         (cnt_clr),
  .chain_q         (chain_q),
  .logic_q         (logic_q),
  .shift_toggles   (shift_toggles),
  .capture_toggles (capture_toggles)
);

// File: tb/sim_gated_scan_chain.sv
module sim_gated_scan_chain;
  localparam int N  = 8;
  localparam int CW = 6;
  localparam int CEIL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0, gate_en = 1'b0, scan_in = 1'b0, cnt_clr = 1'b0;
  logic [N-1:0]  func_d = '0;
  logic          scan_out;
  logic [N-1:0]  logic_q;
  logic [CW-1:0] shift_toggles, capture_toggles;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0]  lq;
    logic          so;
    int            sc;
    int            cc;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [N-1:0] m_chain = '0, m_hold = '0;
  int m_sc = 0, m_cc = 0;

  always #2.5 clk = ~clk;

  gated_scan_chain #(.CHAIN_LEN(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .gate_en(gate_en),
    .scan_in(scan_in), .func_d(func_d), .cnt_clr(cnt_clr),
    .scan_out(scan_out), .logic_q(logic_q),
    .shift_toggles(shift_toggles), .capture_toggles(capture_toggles)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one clock worth of inputs and pushes the expected outcome
  task automatic step(input logic se, input logic ge, input logic si,
                      input logic [N-1:0] d, input logic clr, input string tag);
    logic [N-1:0] nxt;
    int tog;
    exp_t e;
    @(posedge clk); #2;
    scan_en = se; gate_en = ge; scan_in = si; func_d = d; cnt_clr = clr;
    nxt = se ? {m_chain[N-2:0], si} : d;
    tog = 0;
    for (int i = 0; i < N; i++) if (m_chain[i] != nxt[i]) tog++;
    if (clr) begin m_sc = 0; m_cc = 0; end
    else if (se) m_sc = (m_sc + tog > CEIL) ? CEIL : m_sc + tog;
    else         m_cc = (m_cc + tog > CEIL) ? CEIL : m_cc + tog;
    if (!se) m_hold = nxt;
    m_chain = nxt;
    e.lq = (ge && se) ? m_hold : m_chain;
    e.so = m_chain[N-1];
    e.sc = m_sc; e.cc = m_cc; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: samples 1 ns after each edge, before the driver moves inputs
  initial begin
    forever begin
      exp_t e;
      @(posedge clk); #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        chk(e.tag, "logic_q", int'(logic_q), int'(e.lq));
        chk(e.tag, "scan_out", int'(scan_out), int'(e.so));
        chk(e.tag, "shift_toggles", int'(shift_toggles), e.sc);
        chk(e.tag, "capture_toggles", int'(capture_toggles), e.cc);
      end
    end
  end

  task automatic shift_vec(input logic [N-1:0] v, input logic ge, input string tag);
    for (int i = N - 1; i >= 0; i--) step(1'b1, ge, v[i], '0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    // R1: outputs while reset is held
    chk("R1", "logic_q", int'(logic_q), 0);
    chk("R1", "counters", int'(shift_toggles) + int'(capture_toggles), 0);
    @(negedge clk); rst_n = 1'b1;
    // R11: inputs that would load the chain are ignored until the core leaves reset
    func_d = 8'hFF;
    @(posedge clk); #1;
    chk("R11", "logic_q one edge after release", int'(logic_q), 0);
    func_d = '0;
    repeat (2) @(posedge clk);

    // R3 R6 R8: capture with gating on, outputs follow the chain
    step(1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, "R3_R6_R8");
    // R2 R4 R7: shift a new vector in with gating, outputs stay frozen
    shift_vec(8'h3C, 1'b1, "R2_R4_R7");
    // R3 R6 R8: capture a response and make it visible
    step(1'b0, 1'b1, 1'b0, 8'h96, 1'b0, "R3_R6_R8");
    // R2 R5 R7: shift out/in without gating, outputs track the chain
    shift_vec(8'hC3, 1'b0, "R2_R5_R7");
    step(1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, "R3_R6_R8");
    // R10: clear during a shift; the chain still moves
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, "R10");
    step(1'b0, 1'b1, 1'b0, 8'hF0, 1'b1, "R10");
    // R9: alternating stream drives the shift counter to its ceiling
    step(1'b0, 1'b1, 1'b0, 8'h55, 1'b0, "R9");
    for (int k = 0; k < 14; k++) step(1'b1, 1'b1, k[0], '0, 1'b0, "R9");
    // R9: alternating captures saturate the capture counter
    for (int k = 0; k < 10; k++)
      step(1'b0, 1'b0, 1'b0, k[0] ? 8'hAA : 8'h55, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R10");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule